// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects twenty interrupt lines (sixteen from outside the chip and four from on-chip units) and presents one interrupt request to a single processor. Every line has its own configuration word. The word holds an enable mask, a polarity, a choice between edge and level detection, a 4-bit priority and an 8-bit vector number. The controller tracks, for each line, whether the line is requesting and whether it is being serviced. It raises its request only for a line that outranks both the processor's current task priority and whatever is already in service, so nested interrupts follow priority order.

The processor reaches the block through a plain 32-bit word-addressed register port. Reading the acknowledge location returns the vector of the best qualifying line and moves that line into service. Writing zero to the end-of-interrupt location retires the highest-priority line in service. A global configuration word holds the mixed-mode enable and a self-clearing soft reset. A read-only features word describes the block's size.

Word address map: 0x00 global configuration, 0x01 features, 0x02 task priority, 0x03 acknowledge, 0x04 end-of-interrupt, 0x20+i configuration word of line i (lines 0..15 are `ext_irq[15:0]`, lines 16..19 are `int_irq[3:0]`).

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every line reads 0x8000_0000 (masked, all fields zero), the task priority reads 0xF, the global word reads 0, `irq_out` is low and an acknowledge read returns 0xFF.
- R2: A line's configuration word has mask at bit 31, a read-only activity flag at bit 30, polarity at bit 23 (1 = high/rising active, 0 = low/falling active), detection at bit 22 (1 = level, 0 = edge), priority at bits 19:16 and vector at bits 7:0; all other bits read 0 and writes to bit 30 are ignored.
- R3: While a line's activity flag is 1 (requesting or in service), writes leave its polarity, detection, priority and vector unchanged, but the mask bit is still written.
- R4: A line whose mask bit is 1 never requests and never raises `irq_out`.
- R5: In edge mode an unmasked line latches a request on its active transition, keeps it after the input returns, and drops it when acknowledged; the opposite transition latches nothing.
- R6: In level mode an unmasked line requests exactly while its input sits at the active level.
- R7: An acknowledge read returns the vector of the requesting, not-in-service line with the highest priority (lowest line index on a tie) and places that line in service; with no qualifying line it returns 0xFF and changes nothing.
- R8: A line qualifies only if its priority is strictly above the task priority (word 0x02, bits 3:0) and strictly above the highest priority already in service; `irq_out` is high exactly when some line qualifies.
- R9: A write of 0 to the end-of-interrupt word takes the highest-priority in-service line out of service; a write of any other value has no effect.
- R10: Writing 1 to bit 31 of the global word makes that bit read 1 for one cycle, after which it reads 0 and every register and line is back in its R1 state.
- R11: Bit 29 of the global word enables mixed mode and reads back as written; while it is 0, `irq_out` stays low and acknowledge reads return 0xFF.
- R12: The features word reads the line count (20) in bits 26:16, the processor count (1) in bits 12:8 and the version (0x02) in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | 16 | External interrupt lines, lines 0 to 15 |
| int_irq | input | 4 | On-chip interrupt lines, lines 16 to 19 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the acknowledge word) |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong in-service or pending bit is visible at the ports within one register read: the line's activity flag reads back wrong, and the next acknowledge returns the wrong vector or 0xFF. A wrong in-service priority shows up in the same cycle as `irq_out` being raised or withheld against a lower or higher line. A lost edge latch shows after one clock, because `irq_out` stays low after the input returns to idle. The bench walks a table of line pairs, priorities and task thresholds through acknowledge and end-of-interrupt, then drives nesting, lock, mode and soft-reset sequences one by one.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    // word addresses
    localparam logic [ADDR_W-1:0] A_GCR  = 8'h00;
    localparam logic [ADDR_W-1:0] A_FEAT = 8'h01;
    localparam logic [ADDR_W-1:0] A_CTP  = 8'h02;
    localparam logic [ADDR_W-1:0] A_ACK  = 8'h03;
    localparam logic [ADDR_W-1:0] A_EOI  = 8'h04;
    localparam logic [ADDR_W-1:0] A_SRC  = 8'h20;

    // bit positions
    localparam int B_MASK  = 31;
    localparam int B_ACT   = 30;
    localparam int B_RST   = 31;
    localparam int B_MIXED = 29;
    localparam int B_POL   = 23;
    localparam int B_SENSE = 22;
    localparam int B_PRIO  = 16;

    localparam vec_t  NO_VEC   = '1;
    localparam prio_t PRIO_TOP = '1;

    typedef struct packed {
        logic  mask;
        logic  pol;
        logic  sense;
        prio_t prio;
        vec_t  vec;
    } src_cfg_t;

    typedef struct packed {
        src_cfg_t cfg;
        logic     prev;
        logic     edge_pend;
        logic     insvc;
    } src_state_t;

    typedef struct packed {
        logic  mixed;
        logic  busy;
        prio_t ctp;
    } ctl_state_t;

    localparam src_cfg_t CFG_RST = '{mask: 1'b1, pol: 1'b0, sense: 1'b0,
                                     prio: '0, vec: '0};
    localparam ctl_state_t CTL_RST = '{mixed: 1'b0, busy: 1'b0, ctp: PRIO_TOP};

endpackage

// File: rtl/prio_irq_src.sv
module prio_irq_src
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              irq_in,
    input  logic              cfg_we,
    input  src_cfg_t          cfg_wr,
    input  logic              take,
    input  logic              retire,
    output prio_t             prio,
    output vec_t              vec,
    output logic              pend,
    output logic              insvc,
    output logic [DATA_W-1:0] rd_word
);

    src_state_t s_d, s_q;
    logic       lvl_act;
    logic       edge_hit;
    logic       active;

    always_comb begin
        s_d      = s_q;
        lvl_act  = (irq_in == s_q.cfg.pol);
        edge_hit = lvl_act && (s_q.prev != s_q.cfg.pol);
        pend     = !s_q.cfg.mask && (s_q.cfg.sense ? lvl_act : s_q.edge_pend);
        active   = pend || s_q.insvc;

        s_d.prev = irq_in;
        if (edge_hit && !s_q.cfg.mask && !s_q.cfg.sense)
            s_d.edge_pend = 1'b1;
        if (take) begin
            s_d.insvc     = 1'b1;
            s_d.edge_pend = 1'b0;
        end
        if (retire)
            s_d.insvc = 1'b0;
        if (cfg_we) begin
            s_d.cfg.mask = cfg_wr.mask;
            if (!active) begin
                s_d.cfg.pol   = cfg_wr.pol;
                s_d.cfg.sense = cfg_wr.sense;
                s_d.cfg.prio  = cfg_wr.prio;
                s_d.cfg.vec   = cfg_wr.vec;
            end
        end
        if (soft_rst) begin
            s_d.cfg       = CFG_RST;
            s_d.edge_pend = 1'b0;
            s_d.insvc     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{cfg: CFG_RST, prev: 1'b0, edge_pend: 1'b0, insvc: 1'b0};
        else
            s_q <= s_d;
    end

    assign prio  = s_q.cfg.prio;
    assign vec   = s_q.cfg.vec;
    assign insvc = s_q.insvc;

    always_comb begin
        rd_word          = '0;
        rd_word[B_MASK]  = s_q.cfg.mask;
        rd_word[B_ACT]   = active;
        rd_word[B_POL]   = s_q.cfg.pol;
        rd_word[B_SENSE] = s_q.cfg.sense;
        rd_word[B_PRIO +: PRIO_W] = s_q.cfg.prio;
        rd_word[VEC_W-1:0]        = s_q.cfg.vec;
    end

    // R3
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && active && !soft_rst) |=>
            (s_q.cfg.prio == $past(s_q.cfg.prio)) && (s_q.cfg.vec == $past(s_q.cfg.vec)) &&
            (s_q.cfg.pol == $past(s_q.cfg.pol)) && (s_q.cfg.sense == $past(s_q.cfg.sense)));

    // R7
    svc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.insvc) |-> $past(take));

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int NSRC  = 20,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    input  logic [NSRC-1:0]             pend,
    input  logic [NSRC-1:0]             insvc,
    input  prio_t                       ctp,
    output logic                        win_ok,
    output logic [IDX_W-1:0]            win_idx,
    output logic                        svc_any,
    output logic [IDX_W-1:0]            svc_idx
);

    prio_t svc_best;
    prio_t win_best;
    prio_t thr;

    // highest priority in service; strict compare keeps the lowest index
    always_comb begin
        svc_any  = 1'b0;
        svc_idx  = '0;
        svc_best = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (insvc[i] && (!svc_any || prio[i] > svc_best)) begin
                svc_any  = 1'b1;
                svc_idx  = IDX_W'(i);
                svc_best = prio[i];
            end
        end
    end

    assign thr = (svc_any && svc_best > ctp) ? svc_best : ctp;

    always_comb begin
        win_ok   = 1'b0;
        win_idx  = '0;
        win_best = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && !insvc[i] && prio[i] > thr &&
                (!win_ok || prio[i] > win_best)) begin
                win_ok   = 1'b1;
                win_idx  = IDX_W'(i);
                win_best = prio[i];
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int          N_EXT   = 16,
    parameter int          N_INT   = 4,
    parameter logic [7:0]  VERSION = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [N_INT-1:0]  int_irq,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_out
);

    localparam int NSRC  = N_EXT + N_INT;
    localparam int IDX_W = $clog2(NSRC);

    ctl_state_t c_d, c_q;

    logic [NSRC-1:0]             src_in;
    logic [NSRC-1:0][PRIO_W-1:0] prio_arr;
    logic [NSRC-1:0][VEC_W-1:0]  vec_arr;
    logic [NSRC-1:0]             pend_v;
    logic [NSRC-1:0]             insvc_v;
    logic [NSRC-1:0][DATA_W-1:0] rd_words;
    logic [NSRC-1:0]             take_v;
    logic [NSRC-1:0]             retire_v;
    logic [NSRC-1:0]             cfg_we_v;

    logic             win_ok, svc_any;
    logic [IDX_W-1:0] win_idx, svc_idx;
    logic             serve_ok;
    logic             ack_fire;
    logic             eoi_fire;
    vec_t             ack_vec;
    src_cfg_t         cfg_wr;

    assign src_in = {int_irq, ext_irq};

    assign cfg_wr = '{mask:  reg_wdata[B_MASK],
                      pol:   reg_wdata[B_POL],
                      sense: reg_wdata[B_SENSE],
                      prio:  reg_wdata[B_PRIO +: PRIO_W],
                      vec:   reg_wdata[VEC_W-1:0]};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign cfg_we_v[g] = reg_wr && !c_q.busy && (reg_addr == A_SRC + 8'(g));
        assign take_v[g]   = ack_fire && (win_idx == IDX_W'(g));
        assign retire_v[g] = eoi_fire && (svc_idx == IDX_W'(g));

        prio_irq_src u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (c_q.busy),
            .irq_in   (src_in[g]),
            .cfg_we   (cfg_we_v[g]),
            .cfg_wr   (cfg_wr),
            .take     (take_v[g]),
            .retire   (retire_v[g]),
            .prio     (prio_arr[g]),
            .vec      (vec_arr[g]),
            .pend     (pend_v[g]),
            .insvc    (insvc_v[g]),
            .rd_word  (rd_words[g])
        );
    end

    prio_irq_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
        .prio    (prio_arr),
        .pend    (pend_v),
        .insvc   (insvc_v),
        .ctp     (c_q.ctp),
        .win_ok  (win_ok),
        .win_idx (win_idx),
        .svc_any (svc_any),
        .svc_idx (svc_idx)
    );

    assign serve_ok = win_ok && c_q.mixed && !c_q.busy;
    assign irq_out  = serve_ok;
    assign ack_fire = reg_rd && (reg_addr == A_ACK) && serve_ok;
    assign eoi_fire = reg_wr && (reg_addr == A_EOI) && (reg_wdata == '0) &&
                      svc_any && !c_q.busy;

    always_comb begin
        ack_vec = NO_VEC;
        if (serve_ok) begin
            for (int i = 0; i < NSRC; i++)
                if (win_idx == IDX_W'(i))
                    ack_vec = vec_arr[i];
        end
    end

    always_comb begin
        c_d = c_q;
        if (reg_wr && !c_q.busy) begin
            if (reg_addr == A_GCR) begin
                c_d.mixed = reg_wdata[B_MIXED];
                c_d.busy  = reg_wdata[B_RST];
            end
            if (reg_addr == A_CTP)
                c_d.ctp = reg_wdata[PRIO_W-1:0];
        end
        if (c_q.busy)
            c_d = CTL_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            c_q <= CTL_RST;
        else
            c_q <= c_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_GCR: begin
                reg_rdata[B_RST]   = c_q.busy;
                reg_rdata[B_MIXED] = c_q.mixed;
            end
            A_FEAT: reg_rdata = {5'b0, 11'(NSRC), 3'b0, 5'd1, VERSION};
            A_CTP:  reg_rdata[PRIO_W-1:0] = c_q.ctp;
            A_ACK:  reg_rdata[VEC_W-1:0]  = ack_vec;
            default: begin
                for (int i = 0; i < NSRC; i++)
                    if (reg_addr == A_SRC + 8'(i))
                        reg_rdata = rd_words[i];
            end
        endcase
    end

    // R10
    soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.busy |=> !c_q.busy);

    // R10
    soft_rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(c_q.busy) |-> (c_q.ctp == PRIO_TOP) && !c_q.mixed && (insvc_v == '0));

    // R11
    irq_needs_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> c_q.mixed);

    // R8
    irq_task_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (c_q.ctp != PRIO_TOP));

    // R7
    ack_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !eoi_fire) |=> $countones(insvc_v) == $past($countones(insvc_v)) + 1);

    // R9
    eoi_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_fire && !ack_fire) |=> $countones(insvc_v) + 1 == $past($countones(insvc_v)));

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

    localparam logic [7:0] GCR = 8'h00, FEAT = 8'h01, CTP = 8'h02,
                           ACK = 8'h03, EOI = 8'h04, SRC = 8'h20;
    localparam logic [31:0] ACT = 32'h4000_0000;

    // a, prio a, b, prio b, task prio, expected winning line (-1 none)
    localparam int TBL [8][6] = '{
        '{3, 5, 7, 9, 0, 7},
        '{3, 9, 7, 9, 0, 3},
        '{12, 4, 1, 4, 0, 1},
        '{18, 10, 2, 6, 5, 18},
        '{0, 3, 19, 2, 3, -1},
        '{5, 15, 6, 14, 14, 5},
        '{16, 7, 17, 7, 0, 16},
        '{10, 1, 11, 2, 1, 11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] src_lv = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic [31:0] r;

    always #4 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_irq(src_lv[15:0]), .int_irq(src_lv[19:16]),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] cfgw(bit m, bit p, bit s, int pr, int v);
        logic [31:0] w;
        w = '0;
        w[31] = m; w[23] = p; w[22] = s;
        w[19:16] = pr[3:0]; w[7:0] = v[7:0];
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic setsrc(int idx, bit v);
        @(negedge clk);
        src_lv[idx] = v;
    endtask

    task automatic chk_irq(string tag, bit exp);
        @(negedge clk); #2;
        chk(tag, {31'b0, irq_out}, {31'b0, exp});
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq after reset", {31'b0, irq_out}, 32'h0);
        rd(CTP, r);      chk("R1 task prio", r, 32'hF);
        rd(GCR, r);      chk("R1 global word", r, 32'h0);
        rd(SRC + 4, r);  chk("R1 line word", r, 32'h8000_0000);
        rd(ACK, r);      chk("R1 ack empty", r, 32'hFF);
        // R12 features
        rd(FEAT, r);     chk("R12 features", r, 32'h0014_0102);

        // R11 enable mixed mode
        wr(GCR, 32'h2000_0000);
        rd(GCR, r);      chk("R11 mixed readback", r, 32'h2000_0000);
        wr(CTP, 32'h0);

        // R2 layout and read-only activity bit
        wr(SRC + 5, cfgw(1, 1, 1, 11, 8'hA5));
        rd(SRC + 5, r);  chk("R2 layout", r, 32'h80CB_00A5);
        wr(SRC + 5, cfgw(1, 1, 1, 11, 8'hA5) | ACT | 32'h0030_FF00);
        rd(SRC + 5, r);  chk("R2 read-only bits", r, 32'h80CB_00A5);

        // R5 rising edge latch
        wr(SRC + 2, cfgw(0, 1, 0, 6, 8'h22));
        setsrc(2, 1'b1);
        chk_irq("R5 rising latched", 1'b1);
        setsrc(2, 1'b0);
        chk_irq("R5 held after input idle", 1'b1);
        rd(ACK, r);      chk("R5 ack vector", r, 32'h22);
        chk_irq("R5 cleared by ack", 1'b0);
        // R3 lock while in service, mask still writable
        wr(SRC + 2, cfgw(0, 0, 1, 3, 8'h33));
        rd(SRC + 2, r);  chk("R3 locked fields", r, cfgw(0, 1, 0, 6, 8'h22) | ACT);
        wr(SRC + 2, cfgw(1, 0, 1, 3, 8'h33));
        rd(SRC + 2, r);  chk("R3 mask written", r, cfgw(1, 1, 0, 6, 8'h22) | ACT);
        wr(EOI, 32'h0);
        rd(SRC + 2, r);  chk("R9 retire edge line", r, cfgw(1, 1, 0, 6, 8'h22));

        // R5 falling edge, rising ignored
        wr(SRC + 8, cfgw(0, 0, 0, 5, 8'h88));
        setsrc(8, 1'b1);
        chk_irq("R5 wrong edge ignored", 1'b0);
        setsrc(8, 1'b0);
        chk_irq("R5 falling latched", 1'b1);
        rd(ACK, r);      chk("R5 falling ack", r, 32'h88);
        wr(EOI, 32'h0);
        wr(SRC + 8, cfgw(1, 0, 0, 5, 8'h88));

        // R6 level, active low
        setsrc(14, 1'b1);
        wr(SRC + 14, cfgw(0, 0, 1, 9, 8'h0E));
        chk_irq("R6 inactive level", 1'b0);
        setsrc(14, 1'b0);
        chk_irq("R6 active level", 1'b1);
        setsrc(14, 1'b1);
        chk_irq("R6 released level", 1'b0);
        wr(SRC + 14, cfgw(1, 0, 1, 9, 8'h0E));

        // R8 nesting
        wr(SRC + 4, cfgw(0, 1, 1, 5, 8'h44));
        wr(SRC + 9, cfgw(0, 1, 1, 8, 8'h49));
        setsrc(4, 1'b1);
        rd(ACK, r);      chk("R7 first ack", r, 32'h44);
        chk_irq("R8 equal to service blocked", 1'b0);
        setsrc(9, 1'b1);
        chk_irq("R8 higher nests", 1'b1);
        rd(ACK, r);      chk("R8 nested ack", r, 32'h49);
        rd(ACK, r);      chk("R7 nothing left", r, 32'hFF);
        setsrc(9, 1'b0);
        wr(EOI, 32'h1);
        rd(SRC + 9, r);  chk("R9 nonzero eoi ignored", r, cfgw(0, 1, 1, 8, 8'h49) | ACT);
        wr(EOI, 32'h0);
        rd(SRC + 9, r);  chk("R9 top retired", r, cfgw(0, 1, 1, 8, 8'h49));
        rd(SRC + 4, r);  chk("R9 lower kept", r, cfgw(0, 1, 1, 5, 8'h44) | ACT);
        wr(EOI, 32'h0);
        chk_irq("R8 level re-requests", 1'b1);
        wr(CTP, 32'h5);
        chk_irq("R8 equal to task blocked", 1'b0);
        wr(CTP, 32'h4);
        chk_irq("R8 above task", 1'b1);
        // R11 mode off
        wr(GCR, 32'h0);
        chk_irq("R11 irq off", 1'b0);
        rd(ACK, r);      chk("R11 ack off", r, 32'hFF);
        rd(GCR, r);      chk("R11 readback off", r, 32'h0);
        wr(GCR, 32'h2000_0000);
        chk_irq("R11 irq back", 1'b1);
        // R4 mask
        wr(SRC + 4, cfgw(1, 1, 1, 5, 8'h44));
        chk_irq("R4 masked", 1'b0);
        rd(SRC + 4, r);  chk("R4 masked word", r, cfgw(1, 1, 1, 5, 8'h44));
        setsrc(4, 1'b0);

        // R10 soft reset
        wr(CTP, 32'h3);
        wr(GCR, 32'hA000_0000);
        rd(GCR, r);      chk("R10 busy bit", r, 32'hA000_0000);
        rd(GCR, r);      chk("R10 busy cleared", r, 32'h0);
        rd(CTP, r);      chk("R10 task prio", r, 32'hF);
        rd(SRC + 5, r);  chk("R10 line word", r, 32'h8000_0000);
        chk_irq("R10 irq low", 1'b0);

        // R7 arbitration table
        wr(GCR, 32'h2000_0000);
        for (int e = 0; e < 8; e++) begin
            int a, b, w;
            a = TBL[e][0]; b = TBL[e][2]; w = TBL[e][5];
            wr(SRC + 8'(a), cfgw(0, 1, 1, TBL[e][1], 8'h40 + a));
            wr(SRC + 8'(b), cfgw(0, 1, 1, TBL[e][3], 8'h40 + b));
            wr(CTP, 32'(TBL[e][4]));
            setsrc(a, 1'b1);
            setsrc(b, 1'b1);
            chk_irq("R7 table irq", w >= 0);
            rd(ACK, r);
            chk("R7 table vector", r, (w >= 0) ? 32'(8'h40 + w) : 32'hFF);
            setsrc(a, 1'b0);
            setsrc(b, 1'b0);
            wr(EOI, 32'h0);
            wr(SRC + 8'(a), cfgw(1, 1, 1, TBL[e][1], 8'h40 + a));
            wr(SRC + 8'(b), cfgw(1, 1, 1, TBL[e][3], 8'h40 + b));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule